// File: doc/BRIEF.md
# Redundant Axis Channel Selector

This block sits between a group of redundant channel computers and the actuator of one control axis. Every channel carries two lanes, a control lane and a monitor lane. The two lanes compute the same command word from identical inputs. The block compares the two lanes of each channel in every cycle. Only the control-lane word of a single channel, the primary, ever reaches the actuator command output.

A channel whose lanes disagree is taken off the output at once and marked failed. Every channel also sends a heartbeat pulse. A per-channel silence counter declares the channel lost when no pulse arrives for `HB_TIMEOUT` consecutive clock cycles. A failed mark stays set until reset. The primary is always the lowest-numbered channel that is not marked failed, so succession follows the fixed order 0, 1, 2, and so on. When the primary fails, its successor drives the output from the next cycle. When every channel is marked failed, the output stays disabled and an all-failed flag is raised.

Top module: `redundant_axis_selector`

## Requirements
- R1: After reset no channel is marked failed, `primIdx` is 0 and `allFailed` is 0. If the lanes of channel 0 agree, `actEn` is 1 and `actCmd` equals the control-lane word of channel 0.
- R2: Channel i's control word sits at bits [i*CMD_W +: CMD_W] of `ctrlCmd`, and its monitor word at the same position of `monCmd`. While `actEn` is 1, `actCmd` equals the control-lane word of channel `primIdx`. While `actEn` is 0, `actCmd` is all zeros.
- R3: In any cycle where the two lane words of the primary differ, `actEn` is 0 in that same cycle, with no register delay.
- R4: A channel whose lanes differ at a clock edge is marked failed from that edge. If it was the primary, `primIdx` moves to the successor after that edge. `actEn` returns to 1 in the following cycle if the successor's lanes agree.
- R5: A lane mismatch on a channel other than the primary leaves `actEn`, `actCmd` and `primIdx` unchanged in that cycle. That channel is later skipped when succession runs.
- R6: A channel whose `hbPulse` bit is 0 for `HB_TIMEOUT` consecutive clock edges is marked failed at the last of those edges. A pulse at any edge restarts the count, so `HB_TIMEOUT-1` silent edges after a pulse do not mark it failed.
- R7: A failed mark holds until reset. A failed channel whose lanes agree again and whose heartbeat resumes is not selected as primary again.
- R8: When every channel is marked failed, `allFailed` is 1, `actEn` is 0, `actCmd` is 0 and `primIdx` is 0, and this holds until reset.
- R9: `primIdx` is always the lowest index that is not marked failed. If several channels fail at one edge, the lowest remaining healthy index takes over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlCmd | input | NUM_CH*CMD_W | Control-lane command words, channel i at [i*CMD_W +: CMD_W] |
| monCmd | input | NUM_CH*CMD_W | Monitor-lane command words, same packing |
| hbPulse | input | NUM_CH | Heartbeat pulse per channel, bit i for channel i |
| actCmd | output | CMD_W | Actuator command (primary control-lane word, or zero when disabled) |
| actEn | output | 1 | Actuator output enable |
| primIdx | output | $clog2(NUM_CH) | Index of the current primary channel |
| allFailed | output | 1 | Every channel is marked failed |

## Verification
A failed mark that is set wrongly or dropped shows up at `primIdx` one edge after the stimulus that should or should not have set it. A wrong silence count moves the takeover point of R6 off by one edge. That is why the bench stops and restarts heartbeats at the exact edge counts that border the limit. An error in the lane comparison or in the primary mux shows at `actEn` and `actCmd` in the same cycle, because no register lies on that path. A wrong priority order shows as an unexpected `primIdx` the moment two channels fail together.

// File: rtl/rax_pkg.sv
package rax_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic driveEn;   // primary lanes agree and a healthy primary exists
    logic blanked;   // no healthy channel is left
  } rax_strobe_t;

endpackage

// File: rtl/rax_datapath.sv
module rax_datapath
  import rax_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CMD_W  = 16,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH*CMD_W-1:0] ctrlCmd,
  input  logic [NUM_CH*CMD_W-1:0] monCmd,
  input  logic [IDX_W-1:0]        selIdx,
  input  rax_strobe_t             strobes,
  output logic [NUM_CH-1:0]       laneMismatch,
  output logic [CMD_W-1:0]        actCmd,
  output logic                    actEn
);

  logic [CMD_W-1:0] ctrlWord [NUM_CH];

  // Per-channel lane comparison
  for (genvar g = 0; g < NUM_CH; g++) begin : gLane
    assign ctrlWord[g]     = ctrlCmd[g*CMD_W +: CMD_W];
    assign laneMismatch[g] = ctrlWord[g] != monCmd[g*CMD_W +: CMD_W];
  end

  logic gateOpen;
  assign gateOpen = strobes.driveEn && !strobes.blanked;

  // Only the control lane of the selected channel reaches the actuator
  always_comb begin
    actCmd = '0;
    if (gateOpen) actCmd = ctrlWord[selIdx];
  end

  assign actEn = gateOpen;

endmodule

// File: rtl/rax_control.sv
module rax_control
  import rax_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int HB_TIMEOUT = 16,
  localparam int IDX_W     = $clog2(NUM_CH),
  localparam int CNT_W     = $clog2(HB_TIMEOUT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] hbPulse,
  input  logic [NUM_CH-1:0] laneMismatch,
  output logic [IDX_W-1:0]  selIdx,
  output rax_strobe_t       strobes
);

  localparam logic [CNT_W-1:0] LOSS_AT = CNT_W'(HB_TIMEOUT - 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HB_TIMEOUT);

  logic [NUM_CH-1:0] hbLost;
  logic [NUM_CH-1:0] failedQ;

  // Heartbeat silence counters, one per channel
  for (genvar g = 0; g < NUM_CH; g++) begin : gBeat
    logic [CNT_W-1:0] silentCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                silentCnt <= '0;
      else if (hbPulse[g])      silentCnt <= '0;
      else if (silentCnt != CNT_TOP) silentCnt <= silentCnt + 1'b1;
    end

    assign hbLost[g] = !hbPulse[g] && (silentCnt == LOSS_AT);
  end

  // Sticky failure marks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) failedQ <= '0;
    else       failedQ <= failedQ | laneMismatch | hbLost;
  end

  // Fixed-order succession: lowest healthy index
  always_comb begin
    logic found;
    found  = 1'b0;
    selIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && !failedQ[i]) begin
        selIdx = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  logic noneLeft;
  assign noneLeft        = &failedQ;
  assign strobes.blanked = noneLeft;
  assign strobes.driveEn = !noneLeft && !laneMismatch[selIdx];

endmodule

// File: rtl/redundant_axis_selector.sv
module redundant_axis_selector
  import rax_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CMD_W      = 16,
  parameter int HB_TIMEOUT = 16,
  localparam int IDX_W     = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH*CMD_W-1:0] ctrlCmd,
  input  logic [NUM_CH*CMD_W-1:0] monCmd,
  input  logic [NUM_CH-1:0]       hbPulse,
  output logic [CMD_W-1:0]        actCmd,
  output logic                    actEn,
  output logic [IDX_W-1:0]        primIdx,
  output logic                    allFailed
);

  rax_strobe_t       strobes;
  logic [NUM_CH-1:0] laneMismatch;
  logic [IDX_W-1:0]  selIdx;

  rax_control #(
    .NUM_CH     (NUM_CH),
    .HB_TIMEOUT (HB_TIMEOUT)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .hbPulse      (hbPulse),
    .laneMismatch (laneMismatch),
    .selIdx       (selIdx),
    .strobes      (strobes)
  );

  rax_datapath #(
    .NUM_CH (NUM_CH),
    .CMD_W  (CMD_W)
  ) dp_i (
    .ctrlCmd      (ctrlCmd),
    .monCmd       (monCmd),
    .selIdx       (selIdx),
    .strobes      (strobes),
    .laneMismatch (laneMismatch),
    .actCmd       (actCmd),
    .actEn        (actEn)
  );

  assign primIdx   = selIdx;
  assign allFailed = strobes.blanked;

endmodule

// File: rtl/rax_checker.sv
module rax_checker #(
  parameter int NUM_CH = 4,
  parameter int CMD_W  = 16,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_CH*CMD_W-1:0] ctrlCmd,
  input logic [NUM_CH*CMD_W-1:0] monCmd,
  input logic [CMD_W-1:0]        actCmd,
  input logic                    actEn,
  input logic [IDX_W-1:0]        primIdx,
  input logic                    allFailed
);

  logic [CMD_W-1:0] primCtrl;
  logic [CMD_W-1:0] primMon;
  assign primCtrl = ctrlCmd[primIdx*CMD_W +: CMD_W];
  assign primMon  = monCmd[primIdx*CMD_W +: CMD_W];

  // R2: enabled output carries the primary control lane
  assert_cmd_from_primary_R2: assert property (@(posedge clk) disable iff (!rstN)
    actEn |-> actCmd == primCtrl);

  // R2: disabled output is zero
  assert_cmd_zero_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !actEn |-> actCmd == '0);

  // R3: never enabled while the primary lanes disagree
  assert_no_drive_on_mismatch_R3: assert property (@(posedge clk) disable iff (!rstN)
    actEn |-> primCtrl == primMon);

  // R7: succession only moves forward
  assert_idx_forward_R7: assert property (@(posedge clk) disable iff (!rstN)
    !allFailed |=> (allFailed || primIdx >= $past(primIdx)));

  // R8: all-failed is sticky and holds the output off
  assert_allfailed_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    allFailed |=> allFailed);

  assert_allfailed_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    allFailed |-> (!actEn && primIdx == '0));

endmodule

bind redundant_axis_selector rax_checker #(
  .NUM_CH (NUM_CH),
  .CMD_W  (CMD_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .ctrlCmd   (ctrlCmd),
  .monCmd    (monCmd),
  .actCmd    (actCmd),
  .actEn     (actEn),
  .primIdx   (primIdx),
  .allFailed (allFailed)
);

// File: tb/redundant_axis_selector_tb_top.sv
module redundant_axis_selector_tb_top;

  localparam int NC = 4;
  localparam int CW = 16;
  localparam int TO = 8;
  localparam int NSTEP = 9;

  // Row layout: {mismatch mask[3:0], expEn, expIdx[1:0], expAll}
  localparam logic [7:0] STEPS [NSTEP] = '{
    8'h08, 8'h48, 8'h08, 8'h10, 8'h0A, 8'h22, 8'h0E, 8'h86, 8'h01
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NC*CW-1:0]  ctrlCmd = '0;
  logic [NC*CW-1:0]  monCmd = '0;
  logic [NC-1:0]     hbPulse = '1;
  logic [CW-1:0]     actCmd;
  logic              actEn;
  logic [1:0]        primIdx;
  logic              allFailed;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  redundant_axis_selector #(
    .NUM_CH (NC), .CMD_W (CW), .HB_TIMEOUT (TO)
  ) dut_i (
    .clk (clk), .rstN (rstN), .ctrlCmd (ctrlCmd), .monCmd (monCmd),
    .hbPulse (hbPulse), .actCmd (actCmd), .actEn (actEn),
    .primIdx (primIdx), .allFailed (allFailed)
  );

  function automatic logic [CW-1:0] laneWord(input int ch, input int tag);
    return CW'(16'h1000 * (ch + 1) + tag);
  endfunction

  task automatic setLanes(input logic [3:0] mis, input int tag);
    for (int i = 0; i < NC; i++) begin
      ctrlCmd[i*CW +: CW] = laneWord(i, tag);
      monCmd[i*CW +: CW]  = mis[i] ? (laneWord(i, tag) ^ 16'h0001) : laneWord(i, tag);
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    hbPulse = '1;
    setLanes(4'b0000, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string rq;
    logic [7:0] row;

    doReset();
    chk("R1", "idx", primIdx, 0);
    chk("R1", "en", actEn, 1);
    chk("R1", "all", allFailed, 0);
    chk("R1", "cmd", actCmd, laneWord(0, 0));

    // Table walk: mismatch patterns with expected same-cycle outputs
    for (int s = 0; s < NSTEP; s++) begin
      row = STEPS[s];
      case (s)
        1: rq = "R5";
        3: rq = "R3";
        4: rq = "R4";
        6: rq = "R7";
        8: rq = "R8";
        default: rq = "R2";
      endcase
      @(negedge clk);
      setLanes(row[7:4], s + 1);
      #1;
      chk(rq, "en", actEn, row[3]);
      chk(rq, "idx", primIdx, row[2:1]);
      chk(rq, "all", allFailed, row[0]);
      chk("R2", "cmd", actCmd, row[3] ? laneWord(row[2:1], s + 1) : 0);
    end

    // R9: two channels fail at one edge
    doReset();
    @(negedge clk);
    setLanes(4'b0011, 1);
    #1;
    chk("R3", "en", actEn, 0);
    chk("R2", "cmd", actCmd, 0);
    @(negedge clk);
    setLanes(4'b0000, 2);
    #1;
    chk("R9", "idx", primIdx, 2);
    chk("R4", "en", actEn, 1);
    chk("R2", "cmd", actCmd, laneWord(2, 2));

    // R6: heartbeat timeout on channel 0, with a restart
    doReset();
    @(negedge clk);
    hbPulse = 4'b1110;
    repeat (TO - 1) @(negedge clk);
    #1;
    chk("R6", "idx below limit", primIdx, 0);
    hbPulse = 4'b1111;
    @(negedge clk);
    hbPulse = 4'b1110;
    repeat (TO - 1) @(negedge clk);
    #1;
    chk("R6", "idx after restart", primIdx, 0);
    @(negedge clk);
    #1;
    chk("R6", "idx at limit", primIdx, 1);
    chk("R6", "en", actEn, 1);
    chk("R6", "cmd", actCmd, laneWord(1, 0));

    // R7: channel 0 resumes but stays excluded
    hbPulse = 4'b1111;
    repeat (5) @(negedge clk);
    #1;
    chk("R7", "idx", primIdx, 1);

    // R8: all heartbeats stop
    hbPulse = 4'b0000;
    repeat (TO) @(negedge clk);
    #1;
    chk("R8", "all", allFailed, 1);
    chk("R8", "en", actEn, 0);
    chk("R8", "cmd", actCmd, 0);
    chk("R8", "idx", primIdx, 0);
    hbPulse = 4'b1111;
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "all held", allFailed, 1);

    // R1: reset clears every mark
    doReset();
    chk("R1", "all cleared", allFailed, 0);
    chk("R1", "en restored", actEn, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule